// File: doc/BRIEF.md
# Multi-Channel Sample Trigger Matcher

This block watches a stream of 16-channel logic samples and decides when a capture should trigger. Each channel is given a condition by three configuration bits (mask, value, edge). The current sample and the previous valid sample are compared against these conditions. A trigger fires once all participating channels agree. A global configuration word sets how many stages are active and how many low-numbered channels are enabled. Only one stage is evaluated. With zero stages, an all-don't-care idle stage is substituted, so the first valid sample triggers.

After an `arm` pulse, the block counts valid samples starting from zero. On the first matching sample it emits a single-cycle trigger pulse together with that sample's index, then holds a latched flag until the next arm. Alongside the matcher, a small arithmetic path turns a requested pre-trigger position into a stored trigger position. It raises the request to a minimum, caps it at a fraction of memory depth that depends on the capture mode, and aligns it down to a 64-sample boundary.

Top module: `trig_matcher`

## Requirements
- R1: After reset and before the first `arm`, `trig_pulse` and `trig_fired` are 0 and no sample can raise a trigger.
- R2: A channel with mask 0, edge 0 matches when its current bit equals its value bit (value 1 is high level, value 0 is low level).
- R3: A channel with mask 0, edge 1 matches a rising edge (previous 0, current 1) when value is 1, and a falling edge (previous 1, current 0) when value is 0.
- R4: A channel with mask 1, edge 1 matches when its current bit differs from its previous bit, in either direction.
- R5: A channel with mask 1, edge 0 is don't-care. Channels whose index is at or above the enabled-channel count (`cfg_glb[15:4]`) are ignored whatever their configuration.
- R6: On the first valid sample after `arm` there is no previous sample, so any channel with an edge condition fails to match.
- R7: When the stage count (`cfg_glb[3:0]`) is 0, the configured words are replaced by the idle stage (all masks 1, value 0, edge 0), so the first valid sample after `arm` triggers.
- R8: `trig_pulse` is high for exactly one cycle, in the cycle after the matching sample, and at most once per arming. `trig_fired` goes high with it and stays high until `arm`. `trig_idx` gives the zero-based count of valid samples since `arm` at which the match occurred.
- R9: `trig_pos` is `pos_req` raised to at least 64 and then rounded down to a multiple of 64. It is updated one cycle after its inputs.
- R10: Before alignment, `trig_pos` is capped at floor(90% of `mem_depth`) when `stream_mode` is 0 and at floor(10% of `mem_depth`) when `stream_mode` is 1.
- R11: Cycles with `smp_valid` low are ignored. They neither match, nor advance the sample index, nor replace the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Re-arm pulse: clears the latch, index and sample history |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | One bit per channel |
| cfg_mask | input | 16 | Per-channel mask word |
| cfg_value | input | 16 | Per-channel value word |
| cfg_edge | input | 16 | Per-channel edge word |
| cfg_glb | input | 16 | [3:0] stage count, [15:4] enabled-channel count |
| pos_req | input | 32 | Requested trigger position in samples |
| mem_depth | input | 32 | Capture memory depth in samples |
| stream_mode | input | 1 | 1 selects the streaming cap, 0 the buffered cap |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| trig_fired | output | 1 | Latched trigger flag |
| trig_idx | output | 32 | Index of the triggering sample |
| trig_pos | output | 32 | Clamped, aligned trigger position |

## Verification
The trigger pulse, the latched flag and the index all belong to the valid sample taken at a rising edge and are due in the cycle after that edge. The trigger position is due one cycle after its inputs change. The bench drives every input on the falling edge and samples each result at the next falling edge, so exactly one rising edge lies between stimulus and check. The cycle after a pulse is checked separately for the pulse dropping and the flag holding.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int CH_W    = 16;
    localparam int GLB_W   = 16;
    localparam int STG_W   = 4;
    localparam int CNT_W   = GLB_W - STG_W;
    localparam int ATOM    = 64;
    localparam int BUF_PCT = 90;
    localparam int STR_PCT = 10;

    typedef logic [CH_W-1:0] chvec_t;

    // one stage of per-channel condition words
    typedef struct packed {
        chvec_t mask;
        chvec_t value;
        chvec_t edg;
    } stage_t;

    // global word: channel count above, stage count in the low nibble
    typedef struct packed {
        logic [CNT_W-1:0] chans;
        logic [STG_W-1:0] stages;
    } glb_t;

    localparam stage_t IDLE_STAGE = '{mask: '1, value: '0, edg: '0};

    typedef enum logic [2:0] {
        C_ANY,
        C_HIGH,
        C_LOW,
        C_RISE,
        C_FALL,
        C_TOGGLE
    } cond_e;

    function automatic cond_e cond_decode(input logic m, input logic v, input logic e);
        if (!e)
            return m ? C_ANY : (v ? C_HIGH : C_LOW);
        return m ? C_TOGGLE : (v ? C_RISE : C_FALL);
    endfunction

    function automatic logic cond_hit(input cond_e c, input logic prv,
                                      input logic cur, input logic prv_ok);
        case (c)
            C_ANY:    return 1'b1;
            C_HIGH:   return cur;
            C_LOW:    return !cur;
            C_RISE:   return prv_ok && !prv && cur;
            C_FALL:   return prv_ok && prv && !cur;
            C_TOGGLE: return prv_ok && (prv ^ cur);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trig_hist.sv
module trig_hist
    import trig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   valid,
    input  chvec_t data,
    output chvec_t prev,
    output logic   prev_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (clr) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (valid) begin
            prev    <= data;
            prev_ok <= 1'b1;
        end
    end

endmodule

// File: rtl/trig_eval.sv
module trig_eval
    import trig_pkg::*;
(
    input  stage_t           stg,
    input  logic [CNT_W-1:0] chans,
    input  chvec_t           cur,
    input  chvec_t           prev,
    input  logic             prev_ok,
    output logic             all_hit
);

    chvec_t ch_ok;

    for (genvar i = 0; i < CH_W; i++) begin : g_ch
        cond_e cnd;
        logic  en;
        always_comb begin
            cnd      = cond_decode(stg.mask[i], stg.value[i], stg.edg[i]);
            en       = CNT_W'(i) < chans;
            ch_ok[i] = !en || cond_hit(cnd, prev[i], cur[i], prev_ok);
        end
    end

    assign all_hit = &ch_ok;

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl #(
    parameter int IDX_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             valid,
    input  logic             hit,
    output logic             pulse,
    output logic             fired,
    output logic [IDX_W-1:0] idx
);

    logic             armed;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            fired <= 1'b0;
            pulse <= 1'b0;
            cnt   <= '0;
            idx   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            fired <= 1'b0;
            pulse <= 1'b0;
            cnt   <= '0;
        end else begin
            pulse <= 1'b0;
            if (armed && valid) begin
                cnt <= cnt + 1'b1;
                if (hit && !fired) begin
                    pulse <= 1'b1;
                    fired <= 1'b1;
                    idx   <= cnt;
                end
            end
        end
    end

endmodule

// File: rtl/trig_pos_calc.sv
module trig_pos_calc
    import trig_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] req,
    input  logic [POS_W-1:0] depth,
    input  logic             stream,
    output logic [POS_W-1:0] pos
);

    localparam int PW = POS_W + 8;

    logic [PW-1:0] depth_w, cap, lo, clip, aligned;

    always_comb begin
        depth_w = PW'(depth);
        cap     = stream ? (depth_w * PW'(STR_PCT)) / PW'(100)
                         : (depth_w * PW'(BUF_PCT)) / PW'(100);
        lo      = (PW'(req) < PW'(ATOM)) ? PW'(ATOM) : PW'(req);
        clip    = (lo > cap) ? cap : lo;
        aligned = clip & ~PW'(ATOM - 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else
            pos <= aligned[POS_W-1:0];
    end

endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
    import trig_pkg::*;
#(
    parameter int IDX_W = 32,
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             smp_valid,
    input  logic [CH_W-1:0]  smp_data,
    input  logic [CH_W-1:0]  cfg_mask,
    input  logic [CH_W-1:0]  cfg_value,
    input  logic [CH_W-1:0]  cfg_edge,
    input  logic [GLB_W-1:0] cfg_glb,
    input  logic [POS_W-1:0] pos_req,
    input  logic [POS_W-1:0] mem_depth,
    input  logic             stream_mode,
    output logic             trig_pulse,
    output logic             trig_fired,
    output logic [IDX_W-1:0] trig_idx,
    output logic [POS_W-1:0] trig_pos
);

    glb_t   glb;
    stage_t user_stg, act_stg;
    chvec_t prev;
    logic   prev_ok;
    logic   hit;

    always_comb begin
        glb      = glb_t'(cfg_glb);
        user_stg = '{mask: cfg_mask, value: cfg_value, edg: cfg_edge};
        act_stg  = (glb.stages == '0) ? IDLE_STAGE : user_stg;
    end

    trig_hist u_hist (
        .clk     (clk),
        .rst     (rst),
        .clr     (arm),
        .valid   (smp_valid),
        .data    (smp_data),
        .prev    (prev),
        .prev_ok (prev_ok)
    );

    trig_eval u_eval (
        .stg     (act_stg),
        .chans   (glb.chans),
        .cur     (smp_data),
        .prev    (prev),
        .prev_ok (prev_ok),
        .all_hit (hit)
    );

    trig_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .valid (smp_valid),
        .hit   (hit),
        .pulse (trig_pulse),
        .fired (trig_fired),
        .idx   (trig_idx)
    );

    trig_pos_calc #(.POS_W(POS_W)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .req    (pos_req),
        .depth  (mem_depth),
        .stream (stream_mode),
        .pos    (trig_pos)
    );

endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk #(
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             smp_valid,
    input logic [POS_W-1:0] mem_depth,
    input logic             trig_pulse,
    input logic             trig_fired,
    input logic [POS_W-1:0] trig_pos
);

    // R8
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R11
    pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(smp_valid));

    // R8
    fired_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_fired && !arm) |=> trig_fired);

    // R8
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> trig_fired);

    // R9
    pos_align_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pos[5:0] == 6'd0);

    // R9
    pos_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mem_depth) >= POS_W'(1000)) |-> trig_pos >= POS_W'(64));

endmodule

bind trig_matcher trig_matcher_chk #(.POS_W(POS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .smp_valid  (smp_valid),
    .mem_depth  (mem_depth),
    .trig_pulse (trig_pulse),
    .trig_fired (trig_fired),
    .trig_pos   (trig_pos)
);

// File: tb/tb_trig_matcher.sv
module tb_trig_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [15:0] cfg_mask = '1;
    logic [15:0] cfg_value = '0;
    logic [15:0] cfg_edge = '0;
    logic [15:0] cfg_glb = '0;
    logic [31:0] pos_req = '0;
    logic [31:0] mem_depth = 32'd1000;
    logic        stream_mode = 1'b0;
    logic        trig_pulse, trig_fired;
    logic [31:0] trig_idx, trig_pos;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trig_matcher dut (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_mask(cfg_mask), .cfg_value(cfg_value), .cfg_edge(cfg_edge), .cfg_glb(cfg_glb),
        .pos_req(pos_req), .mem_depth(mem_depth), .stream_mode(stream_mode),
        .trig_pulse(trig_pulse), .trig_fired(trig_fired), .trig_idx(trig_idx),
        .trig_pos(trig_pos)
    );

    // {mask, value, edge, glb, s0, s1, hit_on_s0, hit_on_s1}
    localparam int NV = 12;
    localparam logic [97:0] VEC [NV] = '{
        {16'hFFFE, 16'h0001, 16'h0000, 16'h0101, 16'h0001, 16'h0001, 1'b1, 1'b0}, // R2 high
        {16'hFFF7, 16'h0000, 16'h0000, 16'h0101, 16'h0008, 16'h0000, 1'b0, 1'b1}, // R2 low
        {16'hFFDF, 16'h0020, 16'h0020, 16'h0101, 16'h0000, 16'h0020, 1'b0, 1'b1}, // R3 rise
        {16'h7FFF, 16'h0000, 16'h8000, 16'h0101, 16'h8000, 16'h0000, 1'b0, 1'b1}, // R3 fall
        {16'hFFFF, 16'h0000, 16'h0080, 16'h0101, 16'h0000, 16'h0080, 1'b0, 1'b1}, // R4 toggle
        {16'hFFFF, 16'h0000, 16'h0080, 16'h0101, 16'h0080, 16'h0080, 1'b0, 1'b0}, // R4 steady
        {16'hFFFC, 16'h0003, 16'h0002, 16'h0101, 16'h0000, 16'h0003, 1'b0, 1'b1}, // R2 R3 combo
        {16'hFFFC, 16'h0003, 16'h0002, 16'h0101, 16'h0000, 16'h0002, 1'b0, 1'b0}, // R2 combo miss
        {16'hEFFF, 16'h1000, 16'h0000, 16'h0081, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R5 disabled ch
        {16'hFFFE, 16'h0001, 16'h0000, 16'h0100, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R7 no stages
        {16'hFFFB, 16'h0004, 16'h0004, 16'h0101, 16'h0004, 16'h0004, 1'b0, 1'b0}, // R6 first sample
        {16'hFFFF, 16'h0000, 16'h0000, 16'h0101, 16'h1234, 16'h4321, 1'b1, 1'b0}  // R5 all dont-care
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        @(negedge clk); smp_valid = 1'b1; smp_data = d;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic set_pos(input logic [31:0] rq, input logic [31:0] dp, input logic st);
        @(negedge clk); pos_req = rq; mem_depth = dp; stream_mode = st;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and disarmed block
        check("R1 pulse after reset", 32'(trig_pulse), 0);
        check("R1 fired after reset", 32'(trig_fired), 0);
        cfg_glb = 16'h0100;
        send(16'hFFFF);
        check("R1 no trigger before arm", 32'(trig_pulse), 0);
        check("R1 no latch before arm", 32'(trig_fired), 0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            cfg_mask  = VEC[k][97:82];
            cfg_value = VEC[k][81:66];
            cfg_edge  = VEC[k][65:50];
            cfg_glb   = VEC[k][49:34];
            do_arm();
            send(VEC[k][33:18]);
            check($sformatf("vector %0d first sample (R2..R7)", k), 32'(trig_pulse), 32'(VEC[k][1]));
            send(VEC[k][17:2]);
            check($sformatf("vector %0d second sample (R2..R8)", k), 32'(trig_pulse), 32'(VEC[k][0]));
        end

        // R8 R11: index, single pulse, latch, invalid cycles ignored
        @(negedge clk);
        cfg_mask = 16'hFFFE; cfg_value = 16'h0001; cfg_edge = 16'h0000; cfg_glb = 16'h0101;
        do_arm();
        check("R8 fired cleared by arm", 32'(trig_fired), 0);
        send(16'h0000); send(16'h0000); send(16'h0000);
        smp_data = 16'h0001;
        @(negedge clk);
        check("R11 invalid matching cycle", 32'(trig_pulse), 0);
        send(16'h0001);
        check("R8 pulse on match", 32'(trig_pulse), 1);
        check("R8 index skips invalid cycle", trig_idx, 3);
        @(negedge clk);
        check("R8 pulse one cycle", 32'(trig_pulse), 0);
        check("R8 fired latched", 32'(trig_fired), 1);
        send(16'h0001);
        check("R8 once per arming", 32'(trig_pulse), 0);
        check("R8 index held", trig_idx, 3);

        // R11: invalid cycle does not replace previous sample
        @(negedge clk);
        cfg_mask = 16'hFFFE; cfg_value = 16'h0001; cfg_edge = 16'h0001;
        do_arm();
        send(16'h0000);
        smp_data = 16'h0001;
        @(negedge clk);
        send(16'h0001);
        check("R11 history kept across invalid cycle (R3 rise)", 32'(trig_pulse), 1);

        // R9 R10: trigger position
        set_pos(32'd0, 32'd1000, 1'b0);
        check("R9 minimum 64", trig_pos, 64);
        set_pos(32'd500, 32'd1000, 1'b0);
        check("R9 align down", trig_pos, 448);
        set_pos(32'd5000, 32'd1000, 1'b0);
        check("R10 buffered cap", trig_pos, 896);
        set_pos(32'd500, 32'd1000, 1'b1);
        check("R10 streaming cap", trig_pos, 64);
        set_pos(32'd20000, 32'd100000, 1'b1);
        check("R10 streaming cap large", trig_pos, 9984);
        set_pos(32'd128, 32'd100000, 1'b0);
        check("R9 aligned request kept", trig_pos, 128);

        finish_run();
    end

endmodule